// File: doc/BRIEF.md
# Teletext Request Window Generator

This block drives the request strobe that pulls teletext bits from an upstream
data source on each teletext line. A one-clock line-start pulse opens a line;
the strobe is then held high for a window whose nominal length, in clocks, comes
in on an input port. An 8-bit edge-control word trims that window. One 4-bit
field delays the rising edge. The other 4-bit field pulls the falling edge in
from the nominal end, so that fewer bits are requested.

When the falling-edge field is zero, the falling edge follows the rising edge.
Delaying the start then shifts the whole window and leaves its length unchanged.
The control word and the nominal length are captured only on the line-start
pulse, so a line in progress is never reshaped. A counter reports, at each
line-start, how many clocks the strobe was high during the line that just ended.
With a zero control word and a nominal length of 360, each line requests 360 bits.

Top module: `ttx_req_window`

## Requirements
- R1: The control word `edge_ctrl_i` splits into a rising-edge offset in bits [7:4] and a falling-edge offset in bits [3:0], each 0 to 15 clocks.
- R2: The rising-edge offset is r. With a line-start pulse sampled at clock edge E, `req_o` first goes high after edge E+r+1.
- R3: With `edge_ctrl_i` = 8'h00 and a nominal length of 360, the strobe is high for exactly 360 consecutive clocks per line.
- R4: With a falling-edge offset f that is not zero, the strobe stays high for len−r−f clocks. It falls f clocks before the nominal end.
- R5: With f = 0, the strobe stays high for len clocks whatever r is. The falling edge moves by the same amount as the rising edge.
- R6: If the window length works out to zero or less (len = 0, or f ≠ 0 and len ≤ r+f), `req_o` stays low for the whole line.
- R7: Changes on `edge_ctrl_i` or `nom_len_i` between line-start pulses have no effect until the next line-start pulse.
- R8: On each line-start pulse, `bits_per_line_o` takes the number of clocks `req_o` was high since the previous line-start. This appears after that edge; it is zero before any line has finished.
- R9: While `rst_n` is low at a clock edge, `req_o` and `bits_per_line_o` are cleared.
- R10: A line-start pulse ends any window in progress: `req_o` is low in the cycle after it, and the new line's timing starts from that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_start_i | input | 1 | One-clock pulse opening a teletext line |
| edge_ctrl_i | input | 8 | Rising offset [7:4], falling offset [3:0] |
| nom_len_i | input | LEN_W | Nominal window length in clocks |
| req_o | output | 1 | Registered teletext request strobe |
| bits_per_line_o | output | LEN_W+1 | High-clock count of the previous line |

## Verification
The bench swaps the two offset nibbles (0x35 against 0x53). A design that decodes the fields the wrong way round would start the strobe at the wrong clock, even though both lines are the same length. It sweeps the rising offset with a zero falling field, up to 15. A design that fixes the falling edge instead of letting it follow would lose clocks from the window. It probes the emptiness boundary at len = r+f and at len = r+f+1. An off-by-one comparison there would either emit a one-clock glitch or drop the single legal clock. Two further cases rewrite the control word and length in the middle of a window and cut a window short with an early line-start. A design that applies settings at once, or that fails to restart, would change the count it reports.

// File: rtl/ttx_req_pkg.sv
// Shared definitions for the teletext request window generator.
// Assumes the edge-control word is two equal offset nibbles, rise above fall.
package ttx_req_pkg;
    localparam int OFS_W  = 4;
    localparam int CTRL_W = 2 * OFS_W;

    typedef struct packed {
        logic [OFS_W-1:0] rise;
        logic [OFS_W-1:0] fall;
    } edge_ctrl_t;
endpackage

// File: rtl/ttx_win_calc.sv
// Window bound calculator: turns an edge-control word and a nominal length
// into a start position, an exclusive end position and an empty flag.
// Assumes PW is wide enough for the nominal length plus the largest offset.
module ttx_win_calc
    import ttx_req_pkg::*;
#(
    parameter int LEN_W = 10,
    parameter int PW    = LEN_W + 1
) (
    input  edge_ctrl_t       ctrl_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [PW-1:0]    lo_o,
    output logic [PW-1:0]    hi_o,
    output logic             empty_o
);
    logic [PW-1:0] len_x;
    logic [PW-1:0] rise_x;
    logic [PW-1:0] fall_x;

    // Widen the operands and derive the bounds; a zero fall field makes the end track the start.
    always_comb begin
        len_x  = PW'(len_i);
        rise_x = PW'(ctrl_i.rise);
        fall_x = PW'(ctrl_i.fall);
        lo_o   = rise_x;
        if (fall_x == '0) begin
            hi_o    = len_x + rise_x;
            empty_o = (len_x == '0);
        end else begin
            empty_o = (len_x <= rise_x + fall_x);
            hi_o    = empty_o ? rise_x : (len_x - fall_x);
        end
    end
endmodule

// File: rtl/ttx_strobe_gen.sv
// Strobe generator: counts clocks from the line-start pulse and drives a
// registered strobe while the position lies in [lo, hi). Bounds are captured
// only on line-start. Assumes lo < hi whenever empty_i is low.
module ttx_strobe_gen #(
    parameter int PW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start_i,
    input  logic [PW-1:0] lo_i,
    input  logic [PW-1:0] hi_i,
    input  logic          empty_i,
    output logic          req_o
);
    logic [PW-1:0] pos_q;
    logic [PW-1:0] lo_q;
    logic [PW-1:0] hi_q;
    logic          run_q;
    logic          req_q;

    // Position counter, captured bounds and registered strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
            run_q <= 1'b0;
            req_q <= 1'b0;
        end else if (line_start_i) begin
            pos_q <= '0;
            lo_q  <= lo_i;
            hi_q  <= hi_i;
            run_q <= !empty_i;
            req_q <= 1'b0;
        end else begin
            req_q <= run_q && (pos_q >= lo_q) && (pos_q < hi_q);
            if (run_q) begin
                if (pos_q >= hi_q) run_q <= 1'b0;
                else               pos_q <= pos_q + PW'(1);
            end
        end
    end

    assign req_o = req_q;

    // R2: the strobe only rises when the position counter sat on the start bound
    p_rise_at_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> ($past(pos_q) == lo_q));

    // R4: outside a restart, the strobe only falls at the end bound
    p_fall_at_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(req_q) && !$past(line_start_i)) |-> ($past(pos_q) == hi_q));

    // R7: captured bounds hold between line-start pulses
    p_bounds_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start_i |=> ($stable(lo_q) && $stable(hi_q)));

    // R6: an empty line never starts a window
    p_empty_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start_i && empty_i) |=> !run_q);
endmodule

// File: rtl/ttx_bit_counter.sv
// Per-line bit counter: counts strobe-high clocks and publishes the total of
// the finished line on each line-start pulse. Assumes the strobe of the
// cycle that meets line-start belongs to the line that is ending.
module ttx_bit_counter #(
    parameter int LEN_W = 10,
    parameter int PW    = LEN_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start_i,
    input  logic          req_i,
    output logic [PW-1:0] bits_o
);
    localparam logic [PW-1:0] MAX_BITS = PW'((1 << LEN_W) - 1);

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] bits_q;

    // Accumulate high clocks and hand the total over at line-start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bits_q <= '0;
        end else if (line_start_i) begin
            bits_q <= cnt_q + PW'(req_i);
            cnt_q  <= '0;
        end else if (req_i) begin
            cnt_q  <= cnt_q + PW'(1);
        end
    end

    assign bits_o = bits_q;

    // R8: a reported line never exceeds the longest legal window
    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bits_q <= MAX_BITS);
endmodule

// File: rtl/ttx_req_window.sv
// Teletext request window generator top level. Captures the edge-control word
// and nominal length at each line-start pulse, shapes the request strobe and
// reports the high-clock count of each finished line.
// Assumes line_start_i is a single-clock pulse synchronous to clk.
module ttx_req_window
    import ttx_req_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start_i,
    input  logic [7:0]        edge_ctrl_i,
    input  logic [LEN_W-1:0]  nom_len_i,
    output logic              req_o,
    output logic [LEN_W:0]    bits_per_line_o
);
    localparam int PW = LEN_W + 1;

    edge_ctrl_t    ctrl_w;
    logic [PW-1:0] lo_w;
    logic [PW-1:0] hi_w;
    logic          empty_w;

    // Map the raw control byte onto the rise/fall fields.
    assign ctrl_w = edge_ctrl_t'(edge_ctrl_i[CTRL_W-1:0]);

    ttx_win_calc #(.LEN_W(LEN_W), .PW(PW)) u_calc (
        .ctrl_i  (ctrl_w),
        .len_i   (nom_len_i),
        .lo_o    (lo_w),
        .hi_o    (hi_w),
        .empty_o (empty_w)
    );

    ttx_strobe_gen #(.PW(PW)) u_strobe (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start_i (line_start_i),
        .lo_i         (lo_w),
        .hi_i         (hi_w),
        .empty_i      (empty_w),
        .req_o        (req_o)
    );

    ttx_bit_counter #(.LEN_W(LEN_W), .PW(PW)) u_count (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start_i (line_start_i),
        .req_i        (req_o),
        .bits_o       (bits_per_line_o)
    );

    // R10: a line-start pulse always leaves the strobe low in the next cycle
    p_start_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_i |=> !req_o);

    // R9: reset clears the strobe and the reported count
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (!req_o && (bits_per_line_o == '0)));

    // R5: with a zero fall field the window span equals the nominal length
    p_track_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_w.fall == '0) && (nom_len_i != '0)) |-> ((hi_w - lo_w) == PW'(nom_len_i)));

    // R1: the start bound is the upper nibble of the control word
    p_rise_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_w |-> (lo_w == PW'(edge_ctrl_i[7:4])));
endmodule

// File: tb/ttx_req_window_bench.sv
// Scoreboard bench: the driver pushes the expected strobe start and length for
// each line; the monitor measures each line at the ports and compares.
module ttx_req_window_bench;
    localparam int LEN_W = 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             line_start_i;
    logic [7:0]       edge_ctrl_i;
    logic [LEN_W-1:0] nom_len_i;
    logic             req_o;
    logic [LEN_W:0]   bits_per_line_o;

    typedef struct {
        int    first;
        int    cnt;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   tests  = 0;
    int   failed = 0;
    bit   done   = 1'b0;

    always #2 clk = ~clk;

    ttx_req_window #(.LEN_W(LEN_W)) u_ttx_req_window (
        .clk             (clk),
        .rst_n           (rst_n),
        .line_start_i    (line_start_i),
        .edge_ctrl_i     (edge_ctrl_i),
        .nom_len_i       (nom_len_i),
        .req_o           (req_o),
        .bits_per_line_o (bits_per_line_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Driver: pushes the expected line, pulses line-start, optionally rewrites inputs mid-line.
    task automatic run_line(input logic [7:0] ctrl, input int len, input int gap,
                            input string tag, input int chg_at,
                            input logic [7:0] ctrl2, input int len2);
        int r, f, hi, c, top;
        bit empty;
        exp_t e;
        r = int'(ctrl[7:4]);
        f = int'(ctrl[3:0]);
        if (f == 0) begin
            empty = (len == 0);
            hi    = len + r;
        end else begin
            empty = (len <= r + f);
            hi    = len - f;
        end
        top = (hi < gap - 1) ? hi : gap - 1;
        c   = empty ? 0 : top - r;
        if (c < 0) c = 0;
        e.first = (c > 0) ? r + 1 : -1;
        e.cnt   = c;
        e.tag   = tag;
        exp_q.push_back(e);
        @(posedge clk); #1;
        line_start_i = 1'b1;
        edge_ctrl_i  = ctrl;
        nom_len_i    = LEN_W'(len);
        @(posedge clk); #1;
        line_start_i = 1'b0;
        for (int i = 0; i < gap - 2; i++) begin
            if (i == chg_at) begin
                edge_ctrl_i = ctrl2;
                nom_len_i   = LEN_W'(len2);
            end
            @(posedge clk);
        end
    endtask

    // Monitor: measures each line between line-start pulses and compares with the scoreboard.
    int   idx = 0;
    int   m_first = -1;
    int   m_cnt = 0;
    int   prev_cnt = 0;
    bit   have_line = 1'b0;
    exp_t cur;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (line_start_i) begin
                if (have_line) begin
                    idx++;
                    if (req_o) begin
                        if (m_first < 0) m_first = idx;
                        m_cnt++;
                    end
                    cur = exp_q.pop_front();
                    chk(m_first == cur.first, {cur.tag, " strobe start"}, m_first, cur.first);
                    chk(m_cnt == cur.cnt, {cur.tag, " strobe length"}, m_cnt, cur.cnt);
                    prev_cnt = cur.cnt;
                end
                have_line = 1'b1;
                idx       = -1;
                m_first   = -1;
                m_cnt     = 0;
            end else if (have_line) begin
                idx++;
                if (idx == 0) begin
                    chk(req_o == 1'b0, "R10 strobe low after line-start", int'(req_o), 0);
                    chk(int'(bits_per_line_o) == prev_cnt, "R8 reported count",
                        int'(bits_per_line_o), prev_cnt);
                end
                if (req_o) begin
                    if (m_first < 0) m_first = idx;
                    m_cnt++;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        rst_n        = 1'b0;
        line_start_i = 1'b0;
        edge_ctrl_i  = 8'h00;
        nom_len_i    = LEN_W'(360);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_o == 1'b0, "R9 strobe after reset", int'(req_o), 0);
        chk(bits_per_line_o == '0, "R9 count after reset", int'(bits_per_line_o), 0);

        run_line(8'h00, 360, 400, "R3 default 360", -1, 8'h00, 0);
        run_line(8'h30, 360, 400, "R5 tracking r3", -1, 8'h00, 0);
        run_line(8'h35, 360, 400, "R1 R4 r3 f5", -1, 8'h00, 0);
        run_line(8'h53, 360, 400, "R1 R2 r5 f3", -1, 8'h00, 0);
        run_line(8'hF0, 20, 40, "R5 tracking r15", -1, 8'h00, 0);
        run_line(8'h0F, 30, 40, "R4 f15", -1, 8'h00, 0);
        run_line(8'h88, 16, 30, "R6 len equals r+f", -1, 8'h00, 0);
        run_line(8'h00, 0, 20, "R6 zero length", -1, 8'h00, 0);
        run_line(8'h88, 17, 30, "R4 one-clock window", -1, 8'h00, 0);
        run_line(8'h22, 100, 120, "R7 mid-line rewrite", 10, 8'h00, 5);
        run_line(8'h00, 360, 50, "R10 early restart", -1, 8'h00, 0);
        run_line(8'h41, 64, 80, "R2 r4 f1", -1, 8'h00, 0);
        run_line(8'h00, 360, 10, "R8 flush", -1, 8'h00, 0);
        @(posedge clk); #1;
        line_start_i = 1'b1;
        @(posedge clk); #1;
        line_start_i = 1'b0;
        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule